// File: doc/BRIEF.md
# Wide-Screen Signalling Line Serializer

This block sends a wide-screen-signalling code word as a serial bit stream on two chosen scan lines of each interlaced frame, one per field (by default line 20 and line 283). A host loads a 14-bit payload and two 6-bit check values through a small register write port. When a target line begins and signalling is enabled, the block captures the word into a shift register. It then presents one bit per pulse of a bit-strobe timing input, while an active flag marks the transmission window.

In NTSC mode the word is the 14 payload bits followed by the 6-bit check value that belongs to the current field. In PAL mode only the 14 payload bits are sent, and the check registers play no part. The check value is supplied by the host and is not computed here. Waveform shaping is left to logic further down the chain.

Top module: `wss_serializer`

## Requirements
- R1: After reset both check registers hold 6'h3F, the payload register holds 0, `ser_active` is 0 and `ser_out` is 0.
- R2: Register addresses are: 0 holds payload bits 7..0 (`cfg_wdata[7:0]`); 1 holds payload bits 13..8 (`cfg_wdata[5:0]`); 2 holds the check value for line 20 (`cfg_wdata[5:0]`); 3 holds the check value for line 283 (`cfg_wdata[5:0]`). `cfg_rdata` returns the addressed register zero-extended, so bits 7..6 read 0 at addresses 1 to 3.
- R3: A `line_start` pulse with `wss_en` high and `line_num` equal to 20 or 283 raises `ser_active` on the next cycle. A pulse on any other line starts nothing.
- R4: In NTSC mode (`pal_mode`=0) the bits go out in this order: payload bit 0 through bit 13, then check bits 0 through 5. Bit k is on `ser_out` during the window that ends with strobe k+1.
- R5: A word started on line 20 carries the check value at address 2. A word started on line 283 carries the one at address 3.
- R6: In PAL mode (`pal_mode`=1) only the 14 payload bits are sent, and the check registers have no effect on `ser_out`.
- R7: `ser_active` stays high for exactly 20 strobes in NTSC mode and 14 in PAL mode, and falls on the clock edge that takes the last strobe.
- R8: The word is captured at line start. Register writes made during a transmission do not change the bits being sent.
- R9: `ser_out` is 0 whenever `ser_active` is 0.
- R10: With `wss_en` low, `line_start` on a target line starts no transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the addressed register |
| wss_en | input | 1 | Signalling enable |
| pal_mode | input | 1 | 1 selects PAL (payload only), 0 selects NTSC |
| line_num | input | 10 | Current scan line number |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| bit_strobe | input | 1 | One-cycle pulse that advances to the next bit |
| ser_out | output | 1 | Serial data bit |
| ser_active | output | 1 | High while a word is being sent |

## Verification
The assertions check four things on every cycle: the output is quiet outside a transmission, a transmission starts after a qualifying line start, bits hold steady between strobes, and each window closes after the mode's exact strobe count. Other properties depend on values and need the bench's scenarios. These are the bit order, which field's check value is chosen, the register readback with zeroed reserved bits, reset defaults reaching the wire, and immunity to writes made during a transmission.

// File: rtl/wss_serializer.sv
module wss_serializer #(
  parameter int LINE_W    = 10,
  parameter int LINE_A    = 20,
  parameter int LINE_B    = 283,
  parameter int DATA_BITS = 14,
  parameter int CHK_BITS  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       wss_en,
  input  logic       pal_mode,
  input  logic [9:0] line_num,
  input  logic       line_start,
  input  logic       bit_strobe,
  output logic       ser_out,
  output logic       ser_active
);
  localparam int TOT = DATA_BITS + CHK_BITS;
  localparam int CW  = $clog2(TOT + 1);
  localparam int HI  = DATA_BITS - 8;
  localparam logic [LINE_W-1:0] LA = LINE_W'(LINE_A);
  localparam logic [LINE_W-1:0] LB = LINE_W'(LINE_B);
  localparam logic [CW-1:0] N_NTSC = CW'(TOT);
  localparam logic [CW-1:0] N_PAL  = CW'(DATA_BITS);

  logic [DATA_BITS-1:0] payload;
  logic [CHK_BITS-1:0]  chk_a, chk_b;
  logic [TOT-1:0]       sreg;
  logic [CW-1:0]        remain;
  logic                 hit;

  assign hit = line_start && wss_en &&
               (line_num[LINE_W-1:0] == LA || line_num[LINE_W-1:0] == LB);
  assign ser_active = remain != '0;
  assign ser_out    = ser_active & sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payload <= '0;
      chk_a   <= '1;
      chk_b   <= '1;
    end else if (cfg_wr) begin
      case (cfg_addr)
        2'd0: payload[7:0]           <= cfg_wdata;
        2'd1: payload[DATA_BITS-1:8] <= cfg_wdata[HI-1:0];
        2'd2: chk_a                  <= cfg_wdata[CHK_BITS-1:0];
        default: chk_b               <= cfg_wdata[CHK_BITS-1:0];
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      2'd0: cfg_rdata = payload[7:0];
      2'd1: cfg_rdata[HI-1:0] = payload[DATA_BITS-1:8];
      2'd2: cfg_rdata[CHK_BITS-1:0] = chk_a;
      default: cfg_rdata[CHK_BITS-1:0] = chk_b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      remain <= '0;
    end else if (hit) begin
      sreg   <= {(line_num[LINE_W-1:0] == LB) ? chk_b : chk_a, payload};
      remain <= pal_mode ? N_PAL : N_NTSC;
    end else if (ser_active && bit_strobe) begin
      sreg   <= sreg >> 1;
      remain <= remain - 1'b1;
    end
  end

  logic [CW-1:0] seen;
  logic          pal_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= '0;
      pal_q <= 1'b0;
    end else if (hit) begin
      seen  <= '0;
      pal_q <= pal_mode;
    end else if (ser_active && bit_strobe) begin
      seen <= seen + 1'b1;
    end
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_active |-> !ser_out);
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ser_active);
  a_r10_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_active && !hit) |=> !ser_active);
  a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_active && !bit_strobe && !hit) |=> (ser_active && $stable(ser_out)));
  a_r7_exact_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_active) |-> (seen == (pal_q ? N_PAL : N_NTSC)));
  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    ser_active |-> (seen < (pal_q ? N_PAL : N_NTSC)));
endmodule

// File: tb/wss_serializer_test.sv
module wss_serializer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       wss_en = 1'b0;
  logic       pal_mode = 1'b0;
  logic [9:0] line_num = '0;
  logic       line_start = 1'b0;
  logic       bit_strobe = 1'b0;
  logic       ser_out, ser_active;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  string cur_req = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  wss_serializer uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wss_en(wss_en),
    .pal_mode(pal_mode), .line_num(line_num), .line_start(line_start),
    .bit_strobe(bit_strobe), .ser_out(ser_out), .ser_active(ser_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ser_active && ser_out)
      check(1'b0, "R9", ser_out, 0);
    if (rst_n && bit_strobe && ser_active) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 extra bit", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(ser_out == e, cur_req, ser_out, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    tick();
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
    tick();
    cfg_addr = a;
    #1;
    check(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic strobe();
    tick(); bit_strobe = 1'b1;
    tick(); bit_strobe = 1'b0;
    tick();
  endtask

  task automatic run_line(input int ln, input bit pal, input logic [13:0] pl,
                          input logic [5:0] ck, input bit scramble, input string req);
    int n;
    int want;
    cur_req = req;
    for (int i = 0; i < 14; i++) exp_q.push_back(pl[i]);
    if (!pal) for (int i = 0; i < 6; i++) exp_q.push_back(ck[i]);
    want = pal ? 14 : 20;
    tick();
    pal_mode = pal; line_num = 10'(ln); line_start = 1'b1;
    tick();
    line_start = 1'b0;
    check(ser_active == 1'b1, "R3 start", ser_active, 1);
    n = 0;
    while (ser_active && n < 40) begin
      strobe();
      n++;
      if (scramble && n == 5) begin
        wr(2'd0, 8'h00); wr(2'd1, 8'h3F); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      end
    end
    check(n == want, "R7 strobe count", n, want);
    check(exp_q.size() == 0, "R7 bits left", exp_q.size(), 0);
    exp_q.delete();
    strobe();
    check(ser_out == 1'b0, "R9 idle", ser_out, 0);
  endtask

  task automatic no_start(input int ln, input bit en, input string req);
    tick();
    wss_en = en; line_num = 10'(ln); line_start = 1'b1;
    tick();
    line_start = 1'b0;
    strobe();
    check(ser_active == 1'b0, req, ser_active, 0);
    check(ser_out == 1'b0, req, ser_out, 0);
    wss_en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1 reset state
    check(ser_active == 1'b0, "R1 active", ser_active, 0);
    check(ser_out == 1'b0, "R1 out", ser_out, 0);
    rd_check(2'd0, 8'h00, "R1 payload lo");
    rd_check(2'd1, 8'h00, "R1 payload hi");
    rd_check(2'd2, 8'h3F, "R1 check line 20");
    rd_check(2'd3, 8'h3F, "R1 check line 283");
    wss_en = 1'b1;
    // R1: default check bits reach the wire
    run_line(20, 1'b0, 14'h0000, 6'h3F, 1'b0, "R1 default check");
    // R2 writes and readback with reserved bits zero
    wr(2'd0, 8'h5C); wr(2'd1, 8'hEA); wr(2'd2, 8'hD5); wr(2'd3, 8'hEC);
    rd_check(2'd0, 8'h5C, "R2 addr0");
    rd_check(2'd1, 8'h2A, "R2 addr1 reserved zero");
    rd_check(2'd2, 8'h15, "R2 addr2 reserved zero");
    rd_check(2'd3, 8'h2C, "R2 addr3 reserved zero");
    // R4 / R5 NTSC ordering and field selection
    run_line(20, 1'b0, 14'h2A5C, 6'h15, 1'b0, "R4 line 20 order");
    run_line(283, 1'b0, 14'h2A5C, 6'h2C, 1'b0, "R5 line 283 check");
    wr(2'd0, 8'hF1); wr(2'd1, 8'h13);
    run_line(283, 1'b0, 14'h13F1, 6'h2C, 1'b0, "R4 second pattern");
    // R6 PAL: payload only
    run_line(20, 1'b1, 14'h13F1, 6'h00, 1'b0, "R6 PAL line 20");
    run_line(283, 1'b1, 14'h13F1, 6'h00, 1'b0, "R6 PAL line 283");
    // R8 writes mid-transmission
    run_line(20, 1'b0, 14'h13F1, 6'h15, 1'b1, "R8 capture");
    rd_check(2'd1, 8'h3F, "R8 write landed");
    run_line(20, 1'b0, 14'h3F00, 6'h00, 1'b0, "R8 next line uses new value");
    // R3 other line and R10 disabled
    no_start(21, 1'b1, "R3 wrong line");
    no_start(20, 1'b0, "R10 disabled line 20");
    no_start(283, 1'b0, "R10 disabled line 283");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule